// File: doc/BRIEF.md
# Affine Key Candidate Enumerator

This block walks through a run-time chosen interval of free key bits `x` and turns each value into a full key candidate through a fixed affine map over GF(2). The linear part `A` is fixed when the design is elaborated. Column `j` of `A` is the parameter `COL_PAT` rotated left by `j`. The offset `b` is a run-time register, so every candidate meets the key's internal dependencies by construction, and dependent bits are never searched. An initialization vector is XORed on top, so the block emits session keys `sk = A·x ^ b ^ iv`.

One generator feeds `NU` verification units. Each unit is slow and takes many cycles per key. The generator can issue one candidate per clock. It hands candidates to the units in round-robin order and skips units that are busy. The affine map feeds a register stage, which keeps the XOR tree off the output path.

A new subspace of the same interval is chosen by inverting selected bits of `b`. `A` does not change. A flip request while the generator is idle applies the mask and replays the stored interval.

Top module: `keycand_gen`

## Requirements
- R1: While reset is active, and after it ends with no command, `key_vld` is all zero and `gen_done` is low.
- R2: Every issued `key_sk` equals `b ^ iv ^` the XOR of column `j` for every set bit `x[j]` of the issued `key_x`. Column `j` is `COL_PAT` rotated left by `j` bit positions, with bit `KW-1` moving into bit 0.
- R3: After a start, the issued `key_x` values are `cfg_start`, `cfg_start+1` and so on. The last value is the one equal to `cfg_end`, or the all-ones value if that comes first.
- R4: On the cycle after `cfg_load` is sampled, no key is offered. From the next cycle on, a candidate is issued in every cycle in which at least one unit is ready, until the interval is used up.
- R5: `key_vld` has at most one bit set, and only for a unit whose `unit_rdy` bit is high.
- R6: The granted unit is the first ready unit found by searching upward, with wrap-around, from the unit after the last granted one. Unit 0 is the starting point after reset.
- R7: When no unit is ready, no candidate is issued and no `x` value is skipped.
- R8: `gen_done` goes high on the clock edge that accepts the last candidate. It stays high with no `key_vld` until the next start, which clears it.
- R9: `flip_go` while idle replaces `b` with `b ^ flip_mask` and reruns the stored interval with the stored `iv`.
- R10: `flip_go` while candidates remain pending is ignored. The run continues with the old `b` and is not restarted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Start pulse: stores interval, b and iv, and starts a run |
| cfg_start | input | XW | First x value |
| cfg_end | input | XW | Last x value |
| cfg_b | input | KW | Affine offset b |
| cfg_iv | input | KW | Initialization vector |
| flip_go | input | 1 | Invert bits of b and rerun the interval (idle only) |
| flip_mask | input | KW | Bits of b to invert |
| unit_rdy | input | NU | Unit i can take a key this cycle |
| key_vld | output | NU | One-hot grant; the key is taken by that unit |
| key_sk | output | KW | Session key candidate |
| key_x | output | XW | Free-bit value behind key_sk |
| gen_done | output | 1 | Interval fully handed out |

## Verification
The grant in `key_vld` is a same-cycle function of `unit_rdy` and the pending stage. The bench therefore drives readiness on the falling edge and samples one time unit later, in the same cycle. `key_sk` and `key_x` come out of the candidate register. The first candidate appears two rising edges after a start is sampled, and the bench checks that nothing is offered at the falling edge in between. `gen_done` is checked on the falling edge after the cycle that handed out the last value. The bench checks for absence of restart over further cycles with every unit ready.

// File: rtl/kcg_pkg.sv
package kcg_pkg;
  typedef enum logic {XC_IDLE = 1'b0, XC_RUN = 1'b1} xc_state_e;
endpackage

// File: rtl/kcg_xcount.sv
module kcg_xcount #(
  parameter int XW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [XW-1:0] go_start,
  input  logic [XW-1:0] go_end,
  input  logic          adv,
  output logic [XW-1:0] x,
  output logic          run,
  output logic          last
);
  import kcg_pkg::*;
  xc_state_e     st_q;
  logic [XW-1:0] lim_q;

  assign run  = (st_q == XC_RUN);
  assign last = (x == lim_q) || (x == {XW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= XC_IDLE;
      x     <= '0;
      lim_q <= '0;
    end else if (go) begin
      st_q  <= XC_RUN;
      x     <= go_start;
      lim_q <= go_end;
    end else if (adv && run) begin
      if (last) st_q <= XC_IDLE;
      else      x    <= x + XW'(1);
    end
  end
endmodule

// File: rtl/kcg_affine.sv
module kcg_affine #(
  parameter int XW = 8,
  parameter int KW = 16,
  parameter logic [KW-1:0] COL_PAT = 16'h8D2B
) (
  input  logic [XW-1:0] x,
  input  logic [KW-1:0] b,
  input  logic [KW-1:0] iv,
  output logic [KW-1:0] sk
);
  function automatic logic [KW-1:0] column(input int j);
    if (j == 0) return COL_PAT;
    return (COL_PAT << j) | (COL_PAT >> (KW - j));
  endfunction

  logic [KW-1:0] term [XW];
  for (genvar j = 0; j < XW; j++) begin : g_col
    assign term[j] = x[j] ? column(j) : '0;
  end

  always_comb begin
    sk = b ^ iv;
    for (int j = 0; j < XW; j++) sk = sk ^ term[j];
  end
endmodule

// File: rtl/kcg_rr.sv
module kcg_rr #(
  parameter int NU = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          offer,
  input  logic [NU-1:0] rdy,
  output logic [NU-1:0] gnt,
  output logic          fire
);
  localparam int PW = (NU > 1) ? $clog2(NU) : 1;
  logic [PW-1:0] ptr_q;

  function automatic logic [NU-1:0] pick(input logic [NU-1:0] r, input logic [PW-1:0] p);
    logic [NU-1:0] g;
    g = '0;
    for (int k = 0; k < NU; k++) begin
      int i;
      i = (int'(p) + k) % NU;
      if (r[i] && (g == '0)) g[i] = 1'b1;
    end
    return g;
  endfunction

  function automatic logic [PW-1:0] after(input logic [NU-1:0] g);
    logic [PW-1:0] n;
    n = '0;
    for (int i = 0; i < NU; i++)
      if (g[i]) n = (i == NU - 1) ? '0 : PW'(i + 1);
    return n;
  endfunction

  assign gnt  = offer ? pick(rdy, ptr_q) : '0;
  assign fire = |gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_q <= '0;
    else if (fire) ptr_q <= after(gnt);
  end
endmodule

// File: rtl/keycand_gen.sv
module keycand_gen #(
  parameter int XW = 8,
  parameter int KW = 16,
  parameter int NU = 3,
  parameter logic [KW-1:0] COL_PAT = 16'h8D2B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [XW-1:0] cfg_start,
  input  logic [XW-1:0] cfg_end,
  input  logic [KW-1:0] cfg_b,
  input  logic [KW-1:0] cfg_iv,
  input  logic          flip_go,
  input  logic [KW-1:0] flip_mask,
  input  logic [NU-1:0] unit_rdy,
  output logic [NU-1:0] key_vld,
  output logic [KW-1:0] key_sk,
  output logic [XW-1:0] key_x,
  output logic          gen_done
);
  logic [XW-1:0] start_q, end_q, x_q;
  logic [KW-1:0] b_q, iv_q, sk_q;
  logic          full_q, last_q, done_q;

  logic [XW-1:0] x_w;
  logic [KW-1:0] nx_sk;
  logic [NU-1:0] gnt_w;
  logic          run_w, last_w, fire_w;
  logic          idle_w, flip_ok, go_w, adv_w, fill_w;

  assign idle_w  = !run_w && !full_q;
  assign flip_ok = flip_go && idle_w && !cfg_load;
  assign go_w    = cfg_load || flip_ok;
  assign adv_w   = !full_q || fire_w;
  assign fill_w  = run_w && adv_w && !go_w;

  kcg_xcount #(.XW(XW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .go(go_w),
    .go_start(cfg_load ? cfg_start : start_q),
    .go_end(cfg_load ? cfg_end : end_q),
    .adv(adv_w), .x(x_w), .run(run_w), .last(last_w)
  );

  kcg_affine #(.XW(XW), .KW(KW), .COL_PAT(COL_PAT)) u_map (
    .x(x_w), .b(b_q), .iv(iv_q), .sk(nx_sk)
  );

  kcg_rr #(.NU(NU)) u_rr (
    .clk(clk), .rst_n(rst_n), .offer(full_q), .rdy(unit_rdy),
    .gnt(gnt_w), .fire(fire_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0; end_q <= '0; b_q <= '0; iv_q <= '0;
    end else if (cfg_load) begin
      start_q <= cfg_start; end_q <= cfg_end; b_q <= cfg_b; iv_q <= cfg_iv;
    end else if (flip_ok) begin
      b_q <= b_q ^ flip_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0; last_q <= 1'b0; done_q <= 1'b0;
      sk_q   <= '0;   x_q    <= '0;
    end else if (go_w) begin
      full_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (fill_w) begin
        full_q <= 1'b1;
        sk_q   <= nx_sk;
        x_q    <= x_w;
        last_q <= last_w;
      end else if (fire_w) begin
        full_q <= 1'b0;
      end
      if (fire_w && last_q) done_q <= 1'b1;
    end
  end

  assign key_vld  = gnt_w;
  assign key_sk   = sk_q;
  assign key_x    = x_q;
  assign gen_done = done_q;
endmodule

// File: rtl/kcg_chk.sv
module kcg_chk #(
  parameter int XW = 8,
  parameter int NU = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_load,
  input logic          flip_go,
  input logic [NU-1:0] unit_rdy,
  input logic [NU-1:0] key_vld,
  input logic [XW-1:0] key_x,
  input logic          gen_done,
  input logic          fire,
  input logic          last_c
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(key_vld)); // R5
  AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (key_vld & ~unit_rdy) == '0); // R5
  AST_NO_EARLY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_load) |-> key_vld == '0); // R4
  AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last_c && !cfg_load && !flip_go) |=>
      (key_vld == '0 || key_x == $past(key_x) + XW'(1))); // R3
  AST_DONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last_c && !cfg_load && !flip_go) |=> gen_done); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    gen_done |-> key_vld == '0); // R8
endmodule

bind keycand_gen kcg_chk #(.XW(XW), .NU(NU)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .flip_go(flip_go),
  .unit_rdy(unit_rdy), .key_vld(key_vld), .key_x(key_x),
  .gen_done(gen_done), .fire(fire_w), .last_c(last_q)
);

// File: tb/sim_keycand_gen.sv
module sim_keycand_gen;
  localparam int XW = 8;
  localparam int KW = 16;
  localparam int NU = 3;
  localparam logic [KW-1:0] PAT = 16'h8D2B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0, flip_go = 1'b0;
  logic [XW-1:0] cfg_start = '0, cfg_end = '0;
  logic [KW-1:0] cfg_b = '0, cfg_iv = '0, flip_mask = '0;
  logic [NU-1:0] unit_rdy = '0;
  logic [NU-1:0] key_vld;
  logic [KW-1:0] key_sk;
  logic [XW-1:0] key_x;
  logic gen_done;

  always #5 clk = ~clk;

  keycand_gen #(.XW(XW), .KW(KW), .NU(NU), .COL_PAT(PAT)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  int m_ptr = 0;
  logic [KW-1:0] m_b = '0, m_iv = '0;
  logic [XW-1:0] m_start = '0, m_end = '0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [KW-1:0] ref_key(input logic [XW-1:0] x);
    logic [KW-1:0] c, acc;
    c = PAT;
    acc = m_b ^ m_iv;
    for (int j = 0; j < XW; j++) begin
      if (x[j]) acc ^= c;
      c = {c[KW-2:0], c[KW-1]};
    end
    return acc;
  endfunction

  function automatic int first_rdy(input logic [NU-1:0] r, input int p);
    for (int k = 0; k < NU; k++) if (r[(p + k) % NU]) return (p + k) % NU;
    return -1;
  endfunction

  function automatic logic [NU-1:0] pattern(input int mode);
    case (mode)
      0: return '1;
      2: return NU'(3'b100);
      3: return ($urandom % 4 == 0) ? NU'($urandom) : '0;
      default: return NU'($urandom);
    endcase
  endfunction

  task automatic run_range(input logic [XW-1:0] s, input logic [XW-1:0] e,
                           input logic [KW-1:0] b, input logic [KW-1:0] iv,
                           input int mode, input int flip_at, input bit use_flip);
    logic [XW-1:0] nx;
    bit active;
    int cyc, idx;
    @(negedge clk);
    unit_rdy = '1;
    if (use_flip) begin
      flip_go = 1'b1; flip_mask = b; m_b = m_b ^ b;
    end else begin
      cfg_load = 1'b1; cfg_start = s; cfg_end = e; cfg_b = b; cfg_iv = iv;
      m_b = b; m_iv = iv; m_start = s; m_end = e;
    end
    @(negedge clk);
    cfg_load = 1'b0; flip_go = 1'b0;
    #1;
    chk(key_vld == '0, "R4 no key right after start", 64'(key_vld), 0);
    chk(gen_done == 1'b0, "R8 done cleared by start", 64'(gen_done), 0);
    nx = m_start; active = 1; cyc = 0;
    while (active && cyc < 3000) begin
      @(negedge clk);
      unit_rdy = pattern(mode);
      flip_go = (cyc == flip_at);
      flip_mask = '1;
      #1;
      idx = first_rdy(unit_rdy, m_ptr);
      if (idx < 0) begin
        chk(key_vld == '0, "R7 no issue without ready unit", 64'(key_vld), 0);
      end else begin
        chk(key_vld == NU'(1 << idx), "R4 R6 grant", 64'(key_vld), 64'(1 << idx));
        chk(key_x == nx, "R3 x sequence", 64'(key_x), 64'(nx));
        chk(key_sk == ref_key(nx), "R2 session key", 64'(key_sk), 64'(ref_key(nx)));
        m_ptr = (idx + 1) % NU;
        if (nx == m_end || nx == '1) active = 0;
        else nx = nx + XW'(1);
      end
      cyc++;
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      flip_go = 1'b0;
      unit_rdy = '1;
      #1;
      chk(gen_done == 1'b1, "R8 R10 done held after last key", 64'(gen_done), 1);
      chk(key_vld == '0, "R8 R10 no key after done", 64'(key_vld), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk(key_vld == '0, "R1 vld in reset", 64'(key_vld), 0);
    chk(gen_done == 1'b0, "R1 done in reset", 64'(gen_done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    unit_rdy = '1;
    repeat (2) @(negedge clk);
    #1;
    chk(key_vld == '0, "R1 idle after reset", 64'(key_vld), 0);
    chk(gen_done == 1'b0, "R1 done after reset", 64'(gen_done), 0);

    run_range(8'd0, 8'd5, 16'h1234, 16'hA5A5, 0, -1, 0);   // R6 rotation
    run_range(8'hFC, 8'h02, 16'hBEEF, 16'h0F0F, 0, -1, 0); // R3 stop at all-ones
    run_range(8'd7, 8'd7, 16'h0001, 16'h8000, 1, -1, 0);   // R3 single value
    run_range(8'd10, 8'd30, 16'h5555, 16'h3C3C, 2, -1, 0); // R6 busy units skipped
    run_range(8'd40, 8'd60, 16'hC001, 16'h7777, 3, -1, 0); // R7 stalls
    run_range(8'd0, 8'd0, 16'h0A0A, 16'h0, 1, -1, 1);      // R9 flip while idle
    run_range(8'd100, 8'd110, 16'h9999, 16'h1111, 1, 3, 0); // R10 flip while busy
    for (int t = 0; t < 8; t++) begin
      logic [XW-1:0] s;
      s = XW'($urandom);
      run_range(s, s + XW'($urandom % 30), KW'($urandom), KW'($urandom), 1, -1, 0);
    end
    run_range(8'd0, 8'd0, 16'hFF00, 16'h0, 3, 2, 1);       // R9 second flip, R10
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(10 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule